// File: doc/BRIEF.md
# Controller-side PHY update window sequencer

This block opens and closes an update window that the memory controller starts towards the PHY, for example for a periodic delay-line retune. A one-cycle trigger in the idle state raises the update request. The request stays high for at least a programmed minimum number of cycles. A PHY that finishes its work inside that minimum never needs to answer, and the window closes when the minimum runs out. A PHY that needs longer raises its acknowledge and keeps it high. The request then stays up until the acknowledge is seen low.

While a window is open, the block drives a hold-off output so that the command scheduler stops issuing normal traffic. A programmable maximum bounds how long an acknowledge can keep the request alive. If the limit is reached, the request is dropped and a sticky timeout flag is set. A one-cycle completion pulse marks the last held-off cycle. The minimum and maximum are sampled when the trigger is accepted. A build option removes acknowledge handling for PHYs that never drive it.

Top module: `phy_upd_window`

## Requirements
- R1: After reset, req_o, block_o, done_o and timeout_o are all low.
- R2: A trig_i sampled high in the idle state raises req_o and block_o in the next cycle.
- R3: If ack_i stays low, req_o is high for exactly max(min_cyc_i, 1) consecutive cycles.
- R4: If ack_i is high at the clock edge where the minimum is reached, req_o stays high. It falls after the first edge that samples ack_i low. With ack_i high in the first H cycles of the request and max(min,1) <= H < max(max,1), req_o is high for H+1 cycles.
- R5: An acknowledge that falls before the minimum is reached does not lengthen the request. req_o is high for max(min_cyc_i, 1) cycles.
- R6: If ack_i is still high at the edge where the request has lasted max(max_cyc_i, 1) cycles, req_o falls after that many cycles and timeout_o rises with the fall. timeout_o then stays high until the next accepted trigger clears it.
- R7: block_o stays high from the first request cycle through the first cycle after req_o has fallen in which ack_i is low. It falls in the cycle after that.
- R8: done_o is high for exactly one cycle per window. That cycle is the last cycle in which block_o is high, and in it req_o and ack_i are both low.
- R9: trig_i is ignored while block_o is high. Changes to min_cyc_i and max_cyc_i after the trigger is accepted do not affect the open window.
- R10: With ACK_USE = 0, ack_i has no effect, and every window lasts max(min_cyc_i, 1) request cycles plus one closing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start an update window (acted on only when idle) |
| min_cyc_i | input | CNT_W | Minimum request length in cycles |
| max_cyc_i | input | CNT_W | Longest request an acknowledge may keep open |
| ack_i | input | 1 | Acknowledge from the PHY |
| req_o | output | 1 | Update request to the PHY |
| block_o | output | 1 | Hold off normal command issue |
| done_o | output | 1 | One-cycle pulse when the window closes |
| timeout_o | output | 1 | Last window was ended by the maximum limit |

## Verification
The bench builds two copies with CNT_W = 4. One has ACK_USE = 1 and the other ACK_USE = 0, and both share the same stimulus. The narrow counter makes a full sweep practical. Every minimum from 0 to 5, every maximum from 0 to 6 and every acknowledge hold length from 0 to 8 is run. This covers the zero limits, a maximum below the minimum, an acknowledge that ends before, at and after the minimum, and an acknowledge that outlasts the maximum. In every window, a second trigger and all-ones limits are driven in mid-window, which checks that both are ignored.

// File: rtl/upd_pkg.sv
package upd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_HOLD   = 2'd1,
      ST_EXTEND = 2'd2,
      ST_DRAIN  = 2'd3
   } upd_state_e;
endpackage

// File: rtl/upd_win_cnt.sv
module upd_win_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] min_i,
   input  logic [CNT_W-1:0] max_i,
   output logic             min_hit_o,
   output logic             max_hit_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, min_q, max_q;

   // cnt_q holds the number of request cycles so far, counting the current one
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         min_q <= '0;
         max_q <= '0;
      end else if (load_i) begin
         cnt_q <= CNT_ONE;
         min_q <= min_i;
         max_q <= max_i;
      end else if (run_i && cnt_q != CNT_TOP) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   assign min_hit_o = cnt_q >= min_q;
   assign max_hit_o = cnt_q >= max_q;
endmodule

// File: rtl/upd_seq_fsm.sv
module upd_seq_fsm
   import upd_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   input  logic ack_i,
   input  logic min_hit_i,
   input  logic max_hit_i,
   output logic load_o,
   output logic req_o,
   output logic block_o,
   output logic done_o,
   output logic timeout_o
);
   upd_state_e state_q, state_d;
   logic       to_q, to_set;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      to_set  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (trig_i) begin
               state_d = ST_HOLD;
               load_o  = 1'b1;
            end
         end
         ST_HOLD: begin
            if (ack_i && max_hit_i) begin
               state_d = ST_DRAIN;
               to_set  = 1'b1;
            end else if (min_hit_i) begin
               state_d = ack_i ? ST_EXTEND : ST_DRAIN;
            end
         end
         ST_EXTEND: begin
            if (!ack_i) begin
               state_d = ST_DRAIN;
            end else if (max_hit_i) begin
               state_d = ST_DRAIN;
               to_set  = 1'b1;
            end
         end
         ST_DRAIN: begin
            if (!ack_i) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         to_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load_o)      to_q <= 1'b0;
         else if (to_set) to_q <= 1'b1;
      end
   end

   assign req_o     = (state_q == ST_HOLD) || (state_q == ST_EXTEND);
   assign block_o   = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DRAIN) && !ack_i;
   assign timeout_o = to_q;
endmodule

// File: rtl/phy_upd_window.sv
module phy_upd_window #(
   parameter int CNT_W   = 8,
   parameter bit ACK_USE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             trig_i,
   input  logic [CNT_W-1:0] min_cyc_i,
   input  logic [CNT_W-1:0] max_cyc_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic             block_o,
   output logic             done_o,
   output logic             timeout_o
);
   logic ack_eff, load, min_hit, max_hit;

   if (CNT_W < 2) begin : g_bad_width
      $error("phy_upd_window: CNT_W must be at least 2");
   end

   if (ACK_USE) begin : g_ack
      assign ack_eff = ack_i;
   end else begin : g_no_ack
      assign ack_eff = 1'b0;
   end

   upd_win_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .run_i     (req_o),
      .min_i     (min_cyc_i),
      .max_i     (max_cyc_i),
      .min_hit_o (min_hit),
      .max_hit_o (max_hit)
   );

   upd_seq_fsm i_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (trig_i),
      .ack_i     (ack_eff),
      .min_hit_i (min_hit),
      .max_hit_i (max_hit),
      .load_o    (load),
      .req_o     (req_o),
      .block_o   (block_o),
      .done_o    (done_o),
      .timeout_o (timeout_o)
   );
endmodule

// File: rtl/phy_upd_window_chk.sv
module phy_upd_window_chk #(
   parameter bit ACK_USE = 1'b1
) (
   input logic clk_i,
   input logic rst_ni,
   input logic ack_i,
   input logic req_o,
   input logic block_o,
   input logic done_o,
   input logic timeout_o
);
   assert_req_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_o) |-> !$past(block_o));

   assert_req_inside_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |-> block_o);

   assert_block_after_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(req_o) |-> block_o);

   assert_done_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !block_o);

   assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (block_o && !req_o && (!ack_i || !ACK_USE)));

   assert_timeout_at_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(timeout_o) |-> $fell(req_o));

   assert_timeout_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(timeout_o) |-> $rose(req_o));

   assert_no_ack_no_timeout_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ACK_USE |-> !timeout_o);
endmodule

bind phy_upd_window phy_upd_window_chk #(.ACK_USE(ACK_USE)) i_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .ack_i     (ack_i),
   .req_o     (req_o),
   .block_o   (block_o),
   .done_o    (done_o),
   .timeout_o (timeout_o)
);

// File: tb/test_phy_upd_window.sv
module test_phy_upd_window;
   localparam int CLK_P = 10;
   localparam int CW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig = 1'b0;
   logic          ack = 1'b0;
   logic [CW-1:0] mn_in = '0;
   logic [CW-1:0] mx_in = '0;
   logic          req, blk, done, to;
   logic          req2, blk2, done2, to2;
   int            checks = 0;
   int            failures = 0;

   always #(CLK_P/2) clk = ~clk;

   phy_upd_window #(.CNT_W(CW), .ACK_USE(1'b1)) i_phy_upd_window (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .min_cyc_i(mn_in), .max_cyc_i(mx_in),
      .ack_i(ack), .req_o(req), .block_o(blk), .done_o(done), .timeout_o(to));

   phy_upd_window #(.CNT_W(CW), .ACK_USE(1'b0)) i_phy_upd_window_na (
      .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .min_cyc_i(mn_in), .max_cyc_i(mx_in),
      .ack_i(ack), .req_o(req2), .block_o(blk2), .done_o(done2), .timeout_o(to2));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input int mn, input int mx, input int h);
      int mn1, m1, ereq, eblk, eto, ereq2;
      int nreq, lreq, lblk, ndone, kdone, nreq2, lreq2, lblk2, ndone2;
      mn1 = (mn < 1) ? 1 : mn;
      m1  = (mx < 1) ? 1 : mx;
      if (h >= m1) begin
         ereq = m1; eto = 1; eblk = h + 1;
      end else begin
         ereq = (h >= mn1) ? h + 1 : mn1; eto = 0; eblk = ereq + 1;
      end
      ereq2 = mn1;
      nreq = 0; lreq = 0; lblk = 0; ndone = 0; kdone = 0;
      nreq2 = 0; lreq2 = 0; lblk2 = 0; ndone2 = 0;
      @(negedge clk);
      mn_in = CW'(mn); mx_in = CW'(mx); trig = 1'b1; ack = 1'b0;
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         trig = (k == 2);
         if (k == 2) begin mn_in = '1; mx_in = '1; end
         ack = (k <= h);
         #1;
         if (k == 1) begin
            chk(req && blk, "R2 req/block up", {req, blk}, 3);
            chk(!to, "R6 timeout cleared by trigger", to, 0);
         end
         if (req)  begin nreq++;  lreq = k; end
         if (blk)  lblk = k;
         if (done) begin ndone++; kdone = k; end
         if (req2) begin nreq2++; lreq2 = k; end
         if (blk2) lblk2 = k;
         if (done2) ndone2++;
         if (!blk && !blk2) break;
      end
      chk(nreq == ereq && lreq == ereq,
          (h == 0) ? "R3 req length" : (h < mn1 ? "R5 req length" : (eto ? "R6 req length" : "R4 req length")),
          nreq, ereq);
      chk(lblk == eblk, "R7 block length", lblk, eblk);
      chk(ndone == 1 && kdone == eblk, "R8 done pulse cycle", kdone, eblk);
      chk(to == eto[0], "R6 timeout flag", to, eto);
      chk(nreq2 == ereq2 && lreq2 == ereq2, "R10 no-ack req length", nreq2, ereq2);
      chk(lblk2 == ereq2 + 1 && ndone2 == 1 && !to2, "R10 no-ack close", lblk2, ereq2 + 1);
      @(negedge clk);
      #1;
      chk(!req && !blk && !req2 && !blk2, "R9 retrigger ignored", {req, blk, req2, blk2}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!req && !blk && !done && !to, "R1 reset state", {req, blk, done, to}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!req && !blk && !done && !to, "R1 after reset release", {req, blk, done, to}, 0);
      for (int mn = 0; mn <= 5; mn++)
         for (int mx = 0; mx <= 6; mx++)
            for (int h = 0; h <= 8; h++)
               run(mn, mx, h);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule